// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing of an LCD panel from the pixel clock. It drives active-low horizontal sync, vertical sync and output-enable lines and a data-enable strobe. It also gives pixel and line indices, and one-cycle line-start and frame-start pulses, so that a pixel data path can follow the raster. Each horizontal interval has its own configuration value plus a small fixed offset. Each vertical interval is counted in whole line periods.

An optional panel-control mode drives three extra signals for panels with gate drivers and common-electrode reversal. These are a gate clock strobe, a gate start strobe and a reversal level that toggles once per line. All three are placed relative to the falling edge of horizontal sync. Configuration arrives on static inputs. The block takes a snapshot of those inputs at reset and at every frame boundary, so a change made part way through a frame never disturbs the frame in progress.

Top module: `lcdTimingTop`

## Requirements
- R1: While the synchronous reset is asserted, hsyncN, vsyncN and oeN read 1. dataEn, lineStart, frameStart, clsOut, psOut and revOut read 0, and pixelX and lineY read 0.
- R2: hsyncN stays low for hWidth+1 clocks in every line.
- R3: From the falling edge of dataEn to the falling edge of hsyncN is hWait1+1 clocks. From the rising edge of hsyncN to the next rising edge of dataEn is hWait2+3 clocks. dataEn is never high while hsyncN is low.
- R4: The line period (hsyncN fall to fall) is xMax+hWait1+hWidth+hWait2+5 clocks. In each active line, dataEn is high for exactly xMax clocks and oeN is its complement.
- R5: With L the line period, vsyncN stays low for vWidth*L clocks. The first dataEn rise after vsyncN rises comes vWait2*L+1 clocks later. Each frame holds yMax active lines, and a frame lasts (vWidth+vWait2+yMax+vWait1)*L clocks.
- R6: lineStart pulses for one clock every L clocks and coincides with each rise of dataEn. frameStart pulses for one clock, the clock after vsyncN falls, and always together with lineStart. The first clock after reset is released shows frameStart, lineStart and a low vsyncN.
- R7: During dataEn, pixelX counts up from 0 by one each clock. lineY holds the index of the active line within the frame, starting at 0.
- R8: The configuration inputs are sampled only at reset and at the frame boundary. A change made mid-frame takes effect in the first line of the next frame.
- R9: With tftMode set, clsOut rises clsDelay+1 clocks after hsyncN falls and stays high for clsWidth+1 clocks. This needs clsDelay+clsWidth+2 to be no more than L.
- R10: With tftMode set, psOut falls on the same clock as hsyncN and rises psDelay clocks later. This needs psDelay to be at least 1 and less than L.
- R11: With tftMode set, revOut toggles exactly once per line, revDelay+1 clocks after hsyncN falls. This needs revDelay+1 to be less than L.
- R12: With tftMode clear, clsOut, psOut and revOut stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| xMax | input | HCW | Pixels per line |
| hWait1 | input | HCW | Gap from end of active pixels to sync, minus 1 |
| hWidth | input | HCW | Horizontal sync width, minus 1 |
| hWait2 | input | HCW | Gap from sync end to first pixel, minus 3 |
| yMax | input | VCW | Active lines per frame |
| vWidth | input | VCW | Vertical sync width in lines |
| vWait2 | input | VCW | Lines between vertical sync and first active line |
| vWait1 | input | VCW | Lines after the last active line |
| tftMode | input | 1 | Enables the panel-control strobes |
| clsDelay | input | HCW | Gate clock rise delay, minus 1 |
| clsWidth | input | HCW | Gate clock high width, minus 1 |
| psDelay | input | HCW | Gate start rise delay |
| revDelay | input | HCW | Reversal toggle delay, minus 1 |
| hsyncN | output | 1 | Horizontal sync, active low |
| vsyncN | output | 1 | Vertical sync, active low |
| oeN | output | 1 | Output enable, active low |
| dataEn | output | 1 | High during active pixels |
| lineStart | output | 1 | One-clock pulse at each line start |
| frameStart | output | 1 | One-clock pulse at each frame start |
| pixelX | output | HCW | Active pixel index |
| lineY | output | VCW | Active line index |
| clsOut | output | 1 | Gate clock strobe |
| psOut | output | 1 | Gate start strobe |
| revOut | output | 1 | Common-electrode reversal level |

## Verification
At the frame origin, the frame boundary, the configuration reload and a line start all fall on the same clock. On that clock frameStart and lineStart rise together, one clock after the early vertical sync edge. The bench runs back-to-back frames under three configuration sets, including one with no vertical back wait. It checks that both pulses appear on exactly that clock and that every interval measured across the wrap still matches the formulas. A mid-frame configuration change is also applied, and the bench judges its effect by the widths of the data-enable and sync pulses just before and just after the next vertical sync.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;
  parameter int HCW = 12;
  parameter int VCW = 10;

  typedef struct packed {
    logic           on;
    logic [HCW-1:0] clsDly;
    logic [HCW-1:0] clsWid;
    logic [HCW-1:0] psDly;
    logic [HCW-1:0] revDly;
  } tft_t;

  typedef struct packed {
    logic [HCW-1:0] xMax;
    logic [HCW-1:0] hWait1;
    logic [HCW-1:0] hWidth;
    logic [HCW-1:0] hWait2;
    logic [VCW-1:0] yMax;
    logic [VCW-1:0] vWidth;
    logic [VCW-1:0] vWait2;
    logic [VCW-1:0] vWait1;
    tft_t           tft;
  } cfg_t;

  typedef struct packed {
    logic           hAct;
    logic           hSync;
    logic           vSync;
    logic           vAct;
    logic           lineBeg;
    logic           frameBeg;
    logic [HCW-1:0] pixX;
    logic [HCW-1:0] refOff;
    logic [VCW-1:0] lineIdx;
  } strb_t;
endpackage

// File: rtl/lcdTimingCtrl.sv
module lcdTimingCtrl
  import lcdTimingPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  cfg_t cfgIn,
  output tft_t tftR,
  output strb_t strb
);
  cfg_t cfgR;
  logic [HCW-1:0] hCnt, lineLen, syncBeg, syncEnd;
  logic [VCW-1:0] vCnt, actBeg, actEnd, frameLen;
  logic lineLast, frameLast;

  always_comb begin
    lineLen   = cfgR.xMax + cfgR.hWait1 + cfgR.hWidth + cfgR.hWait2 + HCW'(5);
    syncBeg   = cfgR.xMax + cfgR.hWait1 + HCW'(1);
    syncEnd   = syncBeg + cfgR.hWidth + HCW'(1);
    actBeg    = cfgR.vWidth + cfgR.vWait2;
    actEnd    = actBeg + cfgR.yMax;
    frameLen  = actEnd + cfgR.vWait1;
    lineLast  = (hCnt == lineLen - HCW'(1));
    frameLast = (vCnt == frameLen - VCW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
      cfgR <= cfgIn;
    end else if (lineLast) begin
      hCnt <= '0;
      if (frameLast) begin
        vCnt <= '0;
        cfgR <= cfgIn;
      end else begin
        vCnt <= vCnt + VCW'(1);
      end
    end else begin
      hCnt <= hCnt + HCW'(1);
    end
  end

  always_comb begin
    strb.hAct     = (hCnt < cfgR.xMax);
    strb.hSync    = (hCnt >= syncBeg) && (hCnt < syncEnd);
    strb.vAct     = (vCnt >= actBeg) && (vCnt < actEnd);
    // vertical sync leads the frame by one clock and ends one clock early
    strb.vSync    = ((vCnt < cfgR.vWidth) &&
                     !((vCnt == cfgR.vWidth - VCW'(1)) && lineLast)) ||
                    (frameLast && lineLast);
    strb.lineBeg  = (hCnt == '0);
    strb.frameBeg = (hCnt == '0) && (vCnt == '0);
    strb.pixX     = hCnt;
    strb.lineIdx  = vCnt - actBeg;
    strb.refOff   = (hCnt >= syncBeg) ? (hCnt - syncBeg)
                                      : (hCnt + lineLen - syncBeg);
  end

  assign tftR = cfgR.tft;

  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !((hCnt == '0) && (vCnt == '0)) |-> $stable(cfgR)); // R8
  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    hCnt < lineLen); // R4
  AST_VSYNC_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameBeg |-> $past(strb.vSync)); // R6
endmodule

// File: rtl/lcdTimingPath.sv
module lcdTimingPath
  import lcdTimingPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  tft_t           tftCfg,
  input  strb_t          strb,
  output logic           hsyncN,
  output logic           vsyncN,
  output logic           oeN,
  output logic           dataEn,
  output logic           lineStart,
  output logic           frameStart,
  output logic [HCW-1:0] pixelX,
  output logic [VCW-1:0] lineY,
  output logic           clsOut,
  output logic           psOut,
  output logic           revOut
);
  logic deNext, clsHit, psHit, revHit;

  always_comb begin
    deNext = strb.hAct && strb.vAct;
    clsHit = (strb.refOff >= tftCfg.clsDly + HCW'(1)) &&
             (strb.refOff <  tftCfg.clsDly + tftCfg.clsWid + HCW'(2));
    psHit  = (strb.refOff >= tftCfg.psDly);
    revHit = (strb.refOff == tftCfg.revDly + HCW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsyncN     <= 1'b1;
      vsyncN     <= 1'b1;
      oeN        <= 1'b1;
      dataEn     <= 1'b0;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
      pixelX     <= '0;
      lineY      <= '0;
      clsOut     <= 1'b0;
      psOut      <= 1'b0;
      revOut     <= 1'b0;
    end else begin
      hsyncN     <= ~strb.hSync;
      vsyncN     <= ~strb.vSync;
      oeN        <= ~deNext;
      dataEn     <= deNext;
      lineStart  <= strb.lineBeg;
      frameStart <= strb.frameBeg;
      pixelX     <= deNext ? strb.pixX : '0;
      lineY      <= strb.vAct ? strb.lineIdx : '0;
      clsOut     <= tftCfg.on && clsHit;
      psOut      <= tftCfg.on && psHit;
      revOut     <= tftCfg.on ? (revOut ^ revHit) : 1'b0;
    end
  end

  AST_FRAME_WITH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> lineStart); // R6
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !lineStart); // R6
  AST_DE_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> hsyncN); // R3
  AST_TFT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !tftCfg.on |=> (!clsOut && !psOut && !revOut)); // R12
endmodule

// File: rtl/lcdTimingTop.sv
module lcdTimingTop
  import lcdTimingPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [HCW-1:0] xMax,
  input  logic [HCW-1:0] hWait1,
  input  logic [HCW-1:0] hWidth,
  input  logic [HCW-1:0] hWait2,
  input  logic [VCW-1:0] yMax,
  input  logic [VCW-1:0] vWidth,
  input  logic [VCW-1:0] vWait2,
  input  logic [VCW-1:0] vWait1,
  input  logic           tftMode,
  input  logic [HCW-1:0] clsDelay,
  input  logic [HCW-1:0] clsWidth,
  input  logic [HCW-1:0] psDelay,
  input  logic [HCW-1:0] revDelay,
  output logic           hsyncN,
  output logic           vsyncN,
  output logic           oeN,
  output logic           dataEn,
  output logic           lineStart,
  output logic           frameStart,
  output logic [HCW-1:0] pixelX,
  output logic [VCW-1:0] lineY,
  output logic           clsOut,
  output logic           psOut,
  output logic           revOut
);
  cfg_t  cfgIn;
  tft_t  tftR;
  strb_t strb;

  always_comb begin
    cfgIn.xMax       = xMax;
    cfgIn.hWait1     = hWait1;
    cfgIn.hWidth     = hWidth;
    cfgIn.hWait2     = hWait2;
    cfgIn.yMax       = yMax;
    cfgIn.vWidth     = vWidth;
    cfgIn.vWait2     = vWait2;
    cfgIn.vWait1     = vWait1;
    cfgIn.tft.on     = tftMode;
    cfgIn.tft.clsDly = clsDelay;
    cfgIn.tft.clsWid = clsWidth;
    cfgIn.tft.psDly  = psDelay;
    cfgIn.tft.revDly = revDelay;
  end

  lcdTimingCtrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .cfgIn (cfgIn),
    .tftR  (tftR),
    .strb  (strb)
  );

  lcdTimingPath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .tftCfg     (tftR),
    .strb       (strb),
    .hsyncN     (hsyncN),
    .vsyncN     (vsyncN),
    .oeN        (oeN),
    .dataEn     (dataEn),
    .lineStart  (lineStart),
    .frameStart (frameStart),
    .pixelX     (pixelX),
    .lineY      (lineY),
    .clsOut     (clsOut),
    .psOut      (psOut),
    .revOut     (revOut)
  );
endmodule

// File: tb/tb_lcdTimingTop.sv
module tb_lcdTimingTop;
  import lcdTimingPkg::*;

  localparam int NCFG = 3;
  localparam int NCOL = 15;
  // X W1 HW W2 Y VW VW2 VW1 TFT C CW PS RD | line frameLines
  localparam int TBL [NCFG][NCOL] = '{
    '{ 8, 1, 2, 0, 4, 2, 1, 2, 1, 2, 3, 4, 5, 16, 9},
    '{12, 3, 0, 2, 3, 1, 2, 1, 1, 0, 0, 1, 0, 22, 7},
    '{ 5, 0, 1, 1, 2, 3, 0, 1, 0, 1, 1, 2, 2, 12, 6}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [HCW-1:0] xMax, hWait1, hWidth, hWait2, clsDelay, clsWidth, psDelay, revDelay;
  logic [VCW-1:0] yMax, vWidth, vWait2, vWait1;
  logic tftMode;
  logic hsyncN, vsyncN, oeN, dataEn, lineStart, frameStart, clsOut, psOut, revOut;
  logic [HCW-1:0] pixelX;
  logic [VCW-1:0] lineY;

  always #4 clk = ~clk;

  lcdTimingTop dut (
    .clk(clk), .rstN(rstN), .xMax(xMax), .hWait1(hWait1), .hWidth(hWidth),
    .hWait2(hWait2), .yMax(yMax), .vWidth(vWidth), .vWait2(vWait2),
    .vWait1(vWait1), .tftMode(tftMode), .clsDelay(clsDelay),
    .clsWidth(clsWidth), .psDelay(psDelay), .revDelay(revDelay),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .oeN(oeN), .dataEn(dataEn),
    .lineStart(lineStart), .frameStart(frameStart), .pixelX(pixelX),
    .lineY(lineY), .clsOut(clsOut), .psOut(psOut), .revOut(revOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cfgSel  = 0;
  bit measOn  = 1'b0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyCfg(input int i);
    xMax     = HCW'(TBL[i][0]);
    hWait1   = HCW'(TBL[i][1]);
    hWidth   = HCW'(TBL[i][2]);
    hWait2   = HCW'(TBL[i][3]);
    yMax     = VCW'(TBL[i][4]);
    vWidth   = VCW'(TBL[i][5]);
    vWait2   = VCW'(TBL[i][6]);
    vWait1   = VCW'(TBL[i][7]);
    tftMode  = (TBL[i][8] != 0);
    clsDelay = HCW'(TBL[i][9]);
    clsWidth = HCW'(TBL[i][10]);
    psDelay  = HCW'(TBL[i][11]);
    revDelay = HCW'(TBL[i][12]);
  endtask

  // edge-interval monitor
  int cyc, tHsF, tHsR, tDeR, tDeF, tVsF, tVsR, tClsR, tLs, nVs, actLines, revCnt;
  bit prevHs, prevVs, prevDe, prevCls, prevPs, prevRev, fsExp, fsArm, vsRiseArm;

  task automatic initMon();
    cyc = 0; tHsF = -1; tHsR = -1; tDeR = -1; tDeF = -1; tVsF = -1; tVsR = -1;
    tClsR = -1; tLs = -1; nVs = 0; actLines = 0; revCnt = 0;
    prevHs = 1; prevVs = 1; prevDe = 0; prevCls = 0; prevPs = 0; prevRev = 0;
    fsExp = 0; fsArm = 0; vsRiseArm = 0;
  endtask

  always @(negedge clk) begin
    if (measOn) begin
      int L, X, W1, HW, W2, Y, VW, VW2, FR, C, CW, PS, RD;
      bit tft;
      X = TBL[cfgSel][0]; W1 = TBL[cfgSel][1]; HW = TBL[cfgSel][2]; W2 = TBL[cfgSel][3];
      Y = TBL[cfgSel][4]; VW = TBL[cfgSel][5]; VW2 = TBL[cfgSel][6];
      tft = (TBL[cfgSel][8] != 0); C = TBL[cfgSel][9]; CW = TBL[cfgSel][10];
      PS = TBL[cfgSel][11]; RD = TBL[cfgSel][12]; L = TBL[cfgSel][13]; FR = TBL[cfgSel][14];
      cyc++;
      if (fsArm && (frameStart || fsExp)) chk(frameStart == fsExp, "R6 frameStart", int'(frameStart), int'(fsExp));
      fsExp = 0;
      if (frameStart) chk(lineStart, "R6 frame-with-line", int'(lineStart), 1);
      if (lineStart) begin
        if (tLs >= 0) chk(cyc - tLs == L, "R6 lineStart period", cyc - tLs, L);
        tLs = cyc;
      end
      if (prevHs && !hsyncN) begin
        if (tHsF >= 0) begin
          chk(cyc - tHsF == L, "R4 line period", cyc - tHsF, L);
          if (tft) chk(revCnt == 1, "R11 toggles per line", revCnt, 1);
        end
        if (tDeF >= 0 && tDeF > tHsF) chk(cyc - tDeF == W1 + 1, "R3 front wait", cyc - tDeF, W1 + 1);
        if (tft) chk(!psOut, "R10 ps low at sync", int'(psOut), 0);
        tHsF = cyc; revCnt = 0;
      end
      if (!prevHs && hsyncN) begin
        if (tHsF >= 0) chk(cyc - tHsF == HW + 1, "R2 hsync width", cyc - tHsF, HW + 1);
        tHsR = cyc;
      end
      if (!prevDe && dataEn) begin
        if (tHsR >= 0) chk(cyc - tHsR == W2 + 3, "R3 back wait", cyc - tHsR, W2 + 3);
        if (vsRiseArm) chk(cyc - tVsR == VW2 * L + 1, "R5 vsync to data", cyc - tVsR, VW2 * L + 1);
        vsRiseArm = 0;
        chk(int'(lineY) == actLines, "R7 lineY", int'(lineY), actLines);
        chk(lineStart, "R6 lineStart at data", int'(lineStart), 1);
        chk(!oeN, "R4 oeN low", int'(oeN), 0);
        tDeR = cyc;
      end
      if (dataEn && tDeR >= 0) chk(int'(pixelX) == cyc - tDeR, "R7 pixelX", int'(pixelX), cyc - tDeR);
      if (prevDe && !dataEn) begin
        if (tDeR >= 0) chk(cyc - tDeR == X, "R4 data width", cyc - tDeR, X);
        chk(oeN, "R4 oeN high", int'(oeN), 1);
        tDeF = cyc; actLines++;
      end
      if (prevVs && !vsyncN) begin
        if (nVs >= 2) chk(cyc - tVsF == FR * L, "R5 frame period", cyc - tVsF, FR * L);
        if (nVs >= 1) chk(actLines == Y, "R5 active lines", actLines, Y);
        if (nVs >= 1) fsExp = 1;
        fsArm = 1; actLines = 0; tVsF = cyc; nVs++;
      end
      if (!prevVs && vsyncN) begin
        if (nVs >= 2) chk(cyc - tVsF == VW * L, "R5 vsync width", cyc - tVsF, VW * L);
        tVsR = cyc; vsRiseArm = 1;
      end
      if (tft) begin
        if (!prevCls && clsOut && tHsF >= 0) begin
          chk(cyc - tHsF == C + 1, "R9 cls rise", cyc - tHsF, C + 1);
          tClsR = cyc;
        end
        if (prevCls && !clsOut && tClsR >= 0) chk(cyc - tClsR == CW + 1, "R9 cls width", cyc - tClsR, CW + 1);
        if (!prevPs && psOut && tHsF >= 0) chk(cyc - tHsF == PS, "R10 ps rise", cyc - tHsF, PS);
        if (revOut != prevRev) begin
          revCnt++;
          if (tHsF >= 0) chk(cyc - tHsF == RD + 1, "R11 rev toggle", cyc - tHsF, RD + 1);
        end
      end else begin
        chk(!(clsOut || psOut || revOut), "R12 strobes quiet", int'({clsOut, psOut, revOut}), 0);
      end
      prevHs = hsyncN; prevVs = vsyncN; prevDe = dataEn;
      prevCls = clsOut; prevPs = psOut; prevRev = revOut;
    end
  end

  task automatic deWidth(output int w);
    w = 0;
    while (!dataEn) @(negedge clk);
    while (dataEn) begin w++; @(negedge clk); end
  endtask

  task automatic hsWidth(output int w);
    w = 0;
    while (hsyncN) @(negedge clk);
    while (!hsyncN) begin w++; @(negedge clk); end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "WATCHDOG", 0, 1);
    finishRun();
  end

  initial begin
    int w;
    rstN = 1'b0;
    applyCfg(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hsyncN && vsyncN && oeN, "R1 sync lines high", int'({hsyncN, vsyncN, oeN}), 7);
    chk(!(dataEn || lineStart || frameStart), "R1 strobes low", int'({dataEn, lineStart, frameStart}), 0);
    chk(!(clsOut || psOut || revOut), "R1 panel strobes low", int'({clsOut, psOut, revOut}), 0);
    chk(pixelX == '0 && lineY == '0, "R1 indices zero", int'(pixelX) + int'(lineY), 0);

    // R6 first clock after reset is the frame origin
    rstN = 1'b1;
    @(negedge clk);
    chk(frameStart && lineStart, "R6 origin pulses", int'({frameStart, lineStart}), 3);
    chk(!vsyncN, "R6 vsync at origin", int'(vsyncN), 0);

    // R8 mid-frame change waits for the frame boundary
    repeat (18) @(negedge clk);
    applyCfg(1);
    deWidth(w);
    chk(w == 8, "R8 old width kept", w, 8);
    hsWidth(w);
    chk(w == 3, "R8 old sync kept", w, 3);
    while (vsyncN) @(negedge clk);
    deWidth(w);
    chk(w == 12, "R8 new width used", w, 12);
    hsWidth(w);
    chk(w == 1, "R8 new sync used", w, 1);

    // table of configuration vectors under the interval monitor
    for (int i = 0; i < NCFG; i++) begin
      rstN = 1'b0;
      cfgSel = i;
      applyCfg(i);
      @(negedge clk);
      initMon();
      measOn = 1'b1;
      repeat (2) @(negedge clk);
      rstN = 1'b1;
      repeat (4 * TBL[i][13] * TBL[i][14] + 5) @(negedge clk);
      measOn = 1'b0;
      chk(nVs >= 4, "R5 frames observed", nVs, 4);
    end
    finishRun();
  end
endmodule